// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block arbitrates interrupt requests for a small 8-bit CPU core. There are five vectors. Two vectors serve active-low external pins, and each pin can be set to level or falling-edge sensing. Two vectors serve timer overflow pulses. The fifth vector is shared by a serial-port flag and a completion flag from a non-volatile memory. Software programs an enable register and a priority register. Each source is either low or high priority.

The block raises `irq_o` with the address of the winning vector. The core takes the vector by pulsing `ack_i` and signals the end of a handler by pulsing `reti_i`. Between those two pulses the block holds the in-service level. This lets a high-priority request interrupt a low-priority handler, and blocks every other case of nesting. Edge-latched external flags and timer flags clear by themselves when their vector is taken. The serial and memory-completion conditions stay asserted until their owners drop them.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, both registers read 00h, `irq_o` is 0, `vec_addr_o` is 0000h and `act_o` is 00.
- R2: Enable register (`reg_sel_i`=0) layout: bit 7 is global enable, bit 4 is serial, bit 3 is timer 1, bit 2 is external 1, bit 1 is timer 0 and bit 0 is external 0. Bits 6:5 read 0. Priority register (`reg_sel_i`=1) uses the same bit for each source in bits 4:0, where 1 means high. Bits 7:5 read 0.
- R3: When enable bit 7 is 0, `irq_o` stays 0 whatever the individual enables are.
- R4: A source whose own enable bit is 0 never raises `irq_o`.
- R5: `vec_addr_o` is 0003h + 8 × index. The index is 0 for external 0, 1 for timer 0, 2 for external 1, 3 for timer 1 and 4 for serial. `vec_addr_o` is 0000h whenever `irq_o` is 0.
- R6: Among pending requests of one level, the lowest index wins.
- R7: A pending high-priority request wins over any low-priority request, whatever their indices.
- R8: While a low-level handler is in service (`act_o`[0]), only high-priority requests raise `irq_o`. While a high-level handler is in service (`act_o`[1]), no request raises `irq_o`.
- R9: An `ack_i` pulse while `irq_o` is 1 sets the in-service bit of the granted level. A `reti_i` pulse clears `act_o`[1] if it is set, and otherwise clears `act_o`[0].
- R10: In edge mode (`ext_edge_i`[k]=1), a falling edge on the pin latches a request. The request holds after the pin rises and clears when its vector is taken. In level mode, the request follows pin low and is not latched.
- R11: A timer overflow pulse latches a request that clears when its vector is taken.
- R12: The serial vector is requested by `ser_flag_i`, or by `mem_flag_i` when `mem_ie_i` is also 1. Taking the vector leaves that request in place.
- R13: `ack_i` while `irq_o` is 0 has no effect on `act_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects enable register, 1 selects priority register |
| reg_wdata_i | input | 8 | Register write data |
| en_reg_o | output | 8 | Enable register readback |
| prio_reg_o | output | 8 | Priority register readback |
| ext_n_i | input | 2 | External request pins, active low |
| ext_edge_i | input | 2 | Per pin: 1 selects falling-edge sensing, 0 selects level sensing |
| tmr_ovf_i | input | 2 | Timer overflow pulses |
| ser_flag_i | input | 1 | Serial-port flag, cleared by its owner |
| mem_flag_i | input | 1 | Memory completion flag, cleared by its owner |
| mem_ie_i | input | 1 | Local enable of the memory completion flag |
| ack_i | input | 1 | Vector taken by the core |
| reti_i | input | 1 | Handler return pulse |
| irq_o | output | 1 | Interrupt request to the core |
| vec_addr_o | output | 16 | Vector address of the granted source |
| vec_hi_o | output | 1 | Granted request is high priority |
| act_o | output | 2 | In-service levels: bit 1 is high, bit 0 is low |

## Verification
The bench builds the block with its default parameters: five sources, vector base 0003h, a vector step of 8 and 16-bit addresses. With these values every vector address and every polling position can be checked against fixed numbers. Because all five sources are present, one test can assert every source together and then drain them one handler at a time, which exercises the full polling order. The same defaults also reach both nesting levels, high-over-low preemption, and the case where a high-level return exposes a blocked low-level request.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int N_SRC   = 5;
  localparam int N_EXT   = 2;
  localparam int N_TMR   = 2;
  localparam int REG_W   = 8;
  localparam int GLB_BIT = REG_W - 1;
  localparam int SRC_SER = N_SRC - 1;
  localparam int ID_W    = $clog2(N_SRC);
  localparam logic [REG_W-1:0] EN_MASK   = REG_W'((1 << GLB_BIT) | ((1 << N_SRC) - 1));
  localparam logic [REG_W-1:0] PRIO_MASK = REG_W'((1 << N_SRC) - 1);

  typedef enum logic {SEL_EN = 1'b0, SEL_PRIO = 1'b1} reg_sel_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } act_t;

  // externals and timers interleave in the polling order
  function automatic int ext_slot(int k);
    return 2 * k;
  endfunction

  function automatic int tmr_slot(int k);
    return 2 * k + 1;
  endfunction
endpackage

// File: rtl/irq_ext_cap.sv
module irq_ext_cap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_n_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic req_o
);
  logic pin_q;
  logic flag_q;
  logic fall;

  assign fall = pin_q & ~pin_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      pin_q <= pin_n_i;
      if (!edge_mode_i)  flag_q <= 1'b0;
      else if (fall)     flag_q <= 1'b1;
      else if (clr_i)    flag_q <= 1'b0;
    end
  end

  assign req_o = edge_mode_i ? flag_q : ~pin_n_i;

  // R10
  ext_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && clr_i && !fall) |=> !flag_q);
endmodule

// File: rtl/irq_tmr_cap.sv
module irq_tmr_cap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic clr_i,
  output logic req_o
);
  logic flag_q;

  // a new overflow wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (ovf_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign req_o = flag_q;

  // R11
  tmr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !ovf_i) |=> !req_o);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N    = 5,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  prio_i,
  input  logic          act_hi_i,
  input  logic          act_lo_i,
  output logic          valid_o,
  output logic          hi_o,
  output logic [IW-1:0] id_o,
  output logic [N-1:0]  grant_o
);
  logic [N-1:0]  hi_req;
  logic [N-1:0]  lo_req;
  logic          hi_ok;
  logic          lo_ok;

  function automatic logic [IW-1:0] first_set(logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  assign hi_req = req_i & prio_i;
  assign lo_req = req_i & ~prio_i;
  assign hi_ok  = (|hi_req) && !act_hi_i;
  assign lo_ok  = (|lo_req) && !act_hi_i && !act_lo_i;

  always_comb begin
    valid_o = hi_ok | lo_ok;
    hi_o    = hi_ok;
    if (hi_ok)      id_o = first_set(hi_req);
    else if (lo_ok) id_o = first_set(lo_req);
    else            id_o = '0;
  end

  for (genvar g = 0; g < N; g++) begin : g_grant
    assign grant_o[g] = valid_o && (id_o == IW'(g));
  end
endmodule

// File: rtl/irq_level_trk.sv
module irq_level_trk
  import irq_nest_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic take_hi_i,
  input  logic reti_i,
  output act_t act_o
);
  act_t act_q;
  act_t act_d;

  always_comb begin
    act_d = act_q;
    if (reti_i) begin
      if (act_q.hi) act_d.hi = 1'b0;
      else          act_d.lo = 1'b0;
    end
    if (take_i) begin
      if (take_hi_i) act_d.hi = 1'b1;
      else           act_d.lo = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act_d;
  end

  assign act_o = act_q;

  // R9
  reti_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && act_q.hi && !take_i) |=> (!act_q.hi && $stable(act_q.lo)));

  // R9
  take_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && take_hi_i) |=> act_q.hi);
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  en_reg_o,
  output logic [REG_W-1:0]  prio_reg_o,
  input  logic [N_EXT-1:0]  ext_n_i,
  input  logic [N_EXT-1:0]  ext_edge_i,
  input  logic [N_TMR-1:0]  tmr_ovf_i,
  input  logic              ser_flag_i,
  input  logic              mem_flag_i,
  input  logic              mem_ie_i,
  input  logic              ack_i,
  input  logic              reti_i,
  output logic              irq_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              vec_hi_o,
  output logic [1:0]        act_o
);
  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] prio_q;
  logic [N_SRC-1:0] raw_req;
  logic [N_SRC-1:0] gated_req;
  logic [N_SRC-1:0] grant;
  logic [N_SRC-1:0] clr;
  logic [ID_W-1:0]  pick_id;
  logic             pick_valid;
  logic             pick_hi;
  logic             take;
  act_t             act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      prio_q <= '0;
    end else if (reg_we_i) begin
      if (reg_sel_i == SEL_PRIO) prio_q <= reg_wdata_i & PRIO_MASK;
      else                       en_q   <= reg_wdata_i & EN_MASK;
    end
  end

  assign en_reg_o   = en_q;
  assign prio_reg_o = prio_q;

  for (genvar k = 0; k < N_EXT; k++) begin : g_ext
    irq_ext_cap u_cap (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pin_n_i     (ext_n_i[k]),
      .edge_mode_i (ext_edge_i[k]),
      .clr_i       (clr[ext_slot(k)]),
      .req_o       (raw_req[ext_slot(k)])
    );
  end

  for (genvar k = 0; k < N_TMR; k++) begin : g_tmr
    irq_tmr_cap u_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ovf_i  (tmr_ovf_i[k]),
      .clr_i  (clr[tmr_slot(k)]),
      .req_o  (raw_req[tmr_slot(k)])
    );
  end

  // shared vector: both flags are owned and cleared elsewhere
  assign raw_req[SRC_SER] = ser_flag_i | (mem_flag_i & mem_ie_i);

  assign gated_req = raw_req & en_q[N_SRC-1:0] & {N_SRC{en_q[GLB_BIT]}};

  irq_pick #(.N(N_SRC)) u_pick (
    .req_i    (gated_req),
    .prio_i   (prio_q[N_SRC-1:0]),
    .act_hi_i (act.hi),
    .act_lo_i (act.lo),
    .valid_o  (pick_valid),
    .hi_o     (pick_hi),
    .id_o     (pick_id),
    .grant_o  (grant)
  );

  assign take = pick_valid & ack_i;
  assign clr  = grant & {N_SRC{ack_i}};

  irq_level_trk u_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .take_hi_i (pick_hi),
    .reti_i    (reti_i),
    .act_o     (act)
  );

  assign irq_o      = pick_valid;
  assign vec_hi_o   = pick_hi;
  assign vec_addr_o = pick_valid
                    ? ADDR_W'(VEC_BASE) + ADDR_W'(pick_id) * ADDR_W'(VEC_STEP)
                    : '0;
  assign act_o      = act;

  // R8
  hi_no_preempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act.hi |-> !irq_o);

  // R8
  lo_preempt_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act.lo && irq_o) |-> vec_hi_o);

  // R3
  glob_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q[GLB_BIT] |-> !irq_o);

  // R13
  ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !reti_i) |=> $stable(act));
endmodule

// File: tb/irq_nest_ctrl_test.sv
module irq_nest_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_sel_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  en_reg_o, prio_reg_o;
  logic [1:0]  ext_n_i = 2'b11;
  logic [1:0]  ext_edge_i = 2'b00;
  logic [1:0]  tmr_ovf_i = 2'b00;
  logic        ser_flag_i = 1'b0;
  logic        mem_flag_i = 1'b0;
  logic        mem_ie_i = 1'b0;
  logic        ack_i = 1'b0;
  logic        reti_i = 1'b0;
  logic        irq_o;
  logic [15:0] vec_addr_o;
  logic        vec_hi_o;
  logic [1:0]  act_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_nest_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .en_reg_o(en_reg_o), .prio_reg_o(prio_reg_o),
    .ext_n_i(ext_n_i), .ext_edge_i(ext_edge_i), .tmr_ovf_i(tmr_ovf_i),
    .ser_flag_i(ser_flag_i), .mem_flag_i(mem_flag_i), .mem_ie_i(mem_ie_i),
    .ack_i(ack_i), .reti_i(reti_i), .irq_o(irq_o), .vec_addr_o(vec_addr_o),
    .vec_hi_o(vec_hi_o), .act_o(act_o)
  );

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    step();
    reg_we_i = 1'b0;
  endtask

  task automatic ack();
    ack_i = 1'b1; step(); ack_i = 1'b0;
  endtask

  task automatic reti();
    reti_i = 1'b1; step(); reti_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "en_reg", 16'(en_reg_o), 16'h00);
    chk("R1", "prio_reg", 16'(prio_reg_o), 16'h00);
    chk("R1", "irq", 16'(irq_o), 16'h0);
    chk("R1", "vec", vec_addr_o, 16'h0000);
    chk("R1", "act", 16'(act_o), 16'h0);
  endtask

  task automatic t_regs();
    wr(1'b0, 8'hFF);
    chk("R2", "en readback", 16'(en_reg_o), 16'h9F);
    wr(1'b1, 8'hFF);
    chk("R2", "prio readback", 16'(prio_reg_o), 16'h1F);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_global();
    ack();
    chk("R13", "ack while idle keeps act", 16'(act_o), 16'h0);
    wr(1'b0, 8'h1F);
    tmr_ovf_i = 2'b01; step(); tmr_ovf_i = 2'b00;
    chk("R3", "global off masks", 16'(irq_o), 16'h0);
    wr(1'b0, 8'h81);
    chk("R4", "timer0 disabled", 16'(irq_o), 16'h0);
    wr(1'b0, 8'h82);
    chk("R11", "timer0 latched", 16'(irq_o), 16'h1);
    chk("R5", "timer0 vector", vec_addr_o, 16'h000B);
    ack();
    chk("R9", "low level in service", 16'(act_o), 16'h1);
    reti();
    chk("R11", "timer0 cleared on take", 16'(irq_o), 16'h0);
    chk("R9", "return empties", 16'(act_o), 16'h0);
  endtask

  task automatic t_order();
    wr(1'b0, 8'h9F);
    wr(1'b1, 8'h00);
    ext_edge_i = 2'b10; step();
    ser_flag_i = 1'b1; tmr_ovf_i = 2'b11; ext_n_i = 2'b00;
    step(); tmr_ovf_i = 2'b00;
    chk("R6", "ext0 first", vec_addr_o, 16'h0003);
    ack();
    chk("R8", "low blocks low", 16'(irq_o), 16'h0);
    reti();
    ext_n_i[0] = 1'b1; step();
    chk("R10", "level not latched, timer0 next", vec_addr_o, 16'h000B);
    ack(); reti();
    chk("R6", "ext1 third", vec_addr_o, 16'h0013);
    ack(); reti();
    chk("R10", "ext1 edge cleared, timer1 next", vec_addr_o, 16'h001B);
    ack(); reti();
    chk("R6", "serial last", vec_addr_o, 16'h0023);
    ack();
    chk("R9", "serial in service", 16'(act_o), 16'h1);
    reti();
    chk("R12", "serial kept after take", vec_addr_o, 16'h0023);
    ser_flag_i = 1'b0; ext_n_i = 2'b11; ext_edge_i = 2'b00; step();
    chk("R12", "serial dropped", 16'(irq_o), 16'h0);
  endtask

  task automatic t_nest();
    wr(1'b0, 8'h9F);
    wr(1'b1, 8'h10);
    tmr_ovf_i = 2'b01; step(); tmr_ovf_i = 2'b00;
    chk("R5", "timer0 low vector", vec_addr_o, 16'h000B);
    ack();
    ser_flag_i = 1'b1; step();
    chk("R8", "high preempts low", 16'(irq_o), 16'h1);
    chk("R8", "high vector", vec_addr_o, 16'h0023);
    ack();
    chk("R9", "both levels active", 16'(act_o), 16'h3);
    tmr_ovf_i = 2'b10; step(); tmr_ovf_i = 2'b00;
    chk("R8", "high blocks all", 16'(irq_o), 16'h0);
    reti();
    chk("R9", "return pops high", 16'(act_o), 16'h1);
    chk("R8", "high again over low", vec_addr_o, 16'h0023);
    ser_flag_i = 1'b0; step();
    chk("R8", "low blocked under low", 16'(irq_o), 16'h0);
    reti();
    chk("R9", "return pops low", 16'(act_o), 16'h0);
    chk("R6", "timer1 now", vec_addr_o, 16'h001B);
    ser_flag_i = 1'b1; step();
    chk("R7", "high beats lower index", vec_addr_o, 16'h0023);
    chk("R7", "grant level high", 16'(vec_hi_o), 16'h1);
    ser_flag_i = 1'b0; step();
    ack(); reti();
    chk("R11", "timer1 cleared", 16'(irq_o), 16'h0);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_mem();
    wr(1'b0, 8'h90);
    mem_flag_i = 1'b1; mem_ie_i = 1'b0; step();
    chk("R12", "mem local enable off", 16'(irq_o), 16'h0);
    mem_ie_i = 1'b1; step();
    chk("R12", "mem raises serial vector", vec_addr_o, 16'h0023);
    wr(1'b0, 8'h80);
    chk("R4", "serial enable off masks mem", 16'(irq_o), 16'h0);
    mem_flag_i = 1'b0; mem_ie_i = 1'b0; step();
  endtask

  task automatic t_edge();
    wr(1'b0, 8'h81);
    ext_edge_i = 2'b01; step();
    ext_n_i[0] = 1'b0; step();
    chk("R10", "fall latched", vec_addr_o, 16'h0003);
    ext_n_i[0] = 1'b1; step();
    chk("R10", "held after pin rises", 16'(irq_o), 16'h1);
    ack(); reti();
    chk("R10", "cleared by take", 16'(irq_o), 16'h0);
    ext_edge_i = 2'b00; step();
    chk("R10", "level mode pin high idle", 16'(irq_o), 16'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_regs();
    t_global();
    t_order();
    t_nest();
    t_mem();
    t_edge();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule